// File: doc/BRIEF.md
# Sequenced Accumulate Datapath Controller

This block pairs a small accumulating datapath with a Moore-style sequencer that computes (2A + B + 1) mod 16 and leaves it in an accumulator register. The datapath has three parts. A four-way source selector picks one of B, A, the constant one or the constant zero. An adder sums the selected source with the accumulator. The accumulator register has a synchronous load and a synchronous clear. The sequencer produces the datapath's only control signals: the select code, the load and the clear.

A one-cycle start pulse launches a fixed five-step program. The program clears the accumulator, adds A, adds A again, adds B, and then adds the constant one. The doubling comes from adding A twice, and the increment comes from the constant-one source. When the program ends, done is raised. Done and the result then hold until the next start pulse.

Top module: `seq_acc_unit`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released with no start, acc_d is 0 and done is 0.
- R2: If start is sampled high at a rising edge k while the unit is idle or done, then after edge k+5 acc_d equals (2*op_a + op_b + 1) mod 16 and done is 1.
- R3: The source select codes are: 0 selects op_b, 1 selects op_a, 2 selects constant 1 and 3 selects constant 0. The accumulator therefore reads 0 after edge k+1, op_a after edge k+2, (2*op_a) mod 16 after edge k+3 and (2*op_a + op_b) mod 16 after edge k+4.
- R4: While done is 1 and start stays low, done stays 1 and acc_d keeps its value, even if op_a and op_b change.
- R5: A start pulse that arrives while a program is running is ignored. The running program goes on and gives the same values as in R3 and R2.
- R6: A start pulse sampled while done is 1 begins a new program. Done is 0 after that edge, and the new result follows R2.
- R7: All sums wrap modulo 16, so op_a = 15 and op_b = 15 give 14.
- R8: If clear and load are both asserted at an edge, the accumulator becomes 0.
- R9: Done is 0 in every cycle in which the sequencer asserts load or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that launches a program |
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| acc_d | output | 4 | Accumulator contents |
| done | output | 1 | High once the result is in acc_d, until the next start |

## Verification
Start is sampled at edge k. The accumulator then has one due value after each of edges k+1 through k+5, and done is due after edge k+5. Done is also due to drop right after edge k. The bench drives start on a falling edge and samples on each of the following falling edges, so each check lands half a cycle after the edge that produced the value. The bench checks the intermediate accumulator values at every step, as well as the final value. It also checks the hold interval and the cycle in which a restart clears done.

// File: rtl/seq_acc_pkg.sv
package seq_acc_pkg;
  // Source select codes; the datapath decodes these values.
  typedef enum logic [1:0] {
    SEL_B    = 2'd0,
    SEL_A    = 2'd1,
    SEL_ONE  = 2'd2,
    SEL_ZERO = 2'd3
  } src_sel_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLR   = 3'd1,
    ST_ADDA0 = 3'd2,
    ST_ADDA1 = 3'd3,
    ST_ADDB  = 3'd4,
    ST_ADD1  = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/seq_acc_rst_sync.sv
module seq_acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/seq_acc_datapath.sv
module seq_acc_datapath
  import seq_acc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  src_sel_t     sel,
  input  logic         ld,
  input  logic         clr,
  output logic [W-1:0] acc
);
  localparam logic [W-1:0] K_ZERO = '0;
  localparam logic [W-1:0] K_ONE  = W'(1);

  logic [W-1:0] src;
  logic [W-1:0] sum;
  logic [W-1:0] acc_nxt;
  logic         acc_en;

  always_comb begin
    case (sel)
      SEL_B:    src = op_b;
      SEL_A:    src = op_a;
      SEL_ONE:  src = K_ONE;
      SEL_ZERO: src = K_ZERO;
      default:  src = K_ZERO;
    endcase
  end

  // Carry out is dropped, so the sum wraps modulo 2**W.
  assign sum = acc + src;

  // Clear wins over load.
  assign acc_en  = clr | ld;
  assign acc_nxt = clr ? K_ZERO : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_en) acc <= acc_nxt;
  end
endmodule

// File: rtl/seq_acc_ctrl.sv
module seq_acc_ctrl
  import seq_acc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  output src_sel_t sel,
  output logic     ld,
  output logic     clr,
  output logic     done
);
  seq_state_t state, state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:  if (start) state_nxt = ST_CLR;
      ST_CLR:   state_nxt = ST_ADDA0;
      ST_ADDA0: state_nxt = ST_ADDA1;
      ST_ADDA1: state_nxt = ST_ADDB;
      ST_ADDB:  state_nxt = ST_ADD1;
      ST_ADD1:  state_nxt = ST_DONE;
      ST_DONE:  if (start) state_nxt = ST_CLR;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  // Moore outputs: decoded from the state register only.
  always_comb begin
    sel  = SEL_ZERO;
    ld   = 1'b0;
    clr  = 1'b0;
    done = 1'b0;
    case (state)
      ST_CLR:   clr = 1'b1;
      ST_ADDA0: begin sel = SEL_A;   ld = 1'b1; end
      ST_ADDA1: begin sel = SEL_A;   ld = 1'b1; end
      ST_ADDB:  begin sel = SEL_B;   ld = 1'b1; end
      ST_ADD1:  begin sel = SEL_ONE; ld = 1'b1; end
      ST_DONE:  done = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/seq_acc_unit.sv
module seq_acc_unit
  import seq_acc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] acc_d,
  output logic         done
);
  logic     rst_sync_n;
  src_sel_t sel;
  logic     ld;
  logic     clr;

  seq_acc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seq_acc_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .sel   (sel),
    .ld    (ld),
    .clr   (clr),
    .done  (done)
  );

  seq_acc_datapath #(.W(W)) u_dp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .sel   (sel),
    .ld    (ld),
    .clr   (clr),
    .acc   (acc_d)
  );
endmodule

// File: rtl/seq_acc_chk.sv
module seq_acc_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] a,
  input logic [W-1:0] d,
  input logic         done,
  input logic [1:0]   sel,
  input logic         ld,
  input logic         clr
);
  // R8: a clear leaves the accumulator at zero.
  a_r8_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (d == '0));

  // R3: a load with the A code adds op_a to the accumulator, modulo 2**W.
  a_r3_add_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr && sel == 2'd1) |=> (d == W'($past(d) + $past(a))));

  // R4: with no start, done and the result both hold.
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(d)));

  // R6: a start while done begins a new clear step.
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && clr));

  // R9: done is low whenever the datapath is being driven.
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ld || clr) |-> !done);

  // R8: the sequencer never asks for load and clear together.
  a_r8_ctl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld, clr}));
endmodule

bind seq_acc_unit seq_acc_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .start (start),
  .a     (op_a),
  .d     (acc_d),
  .done  (done),
  .sel   (sel),
  .ld    (ld),
  .clr   (clr)
);

// File: tb/test_seq_acc_unit.sv
`timescale 1ns/1ps
module test_seq_acc_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] op_a;
  logic [3:0] op_b;
  logic [3:0] acc_d;
  logic       done;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  seq_acc_unit #(.W(4)) i_seq_acc_unit (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op_a  (op_a),
    .op_b  (op_b),
    .acc_d (acc_d),
    .done  (done)
  );

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Pulses start; optionally pokes start again at a busy step (1..4).
  // Checks every step of the program.
  task automatic run_prog(input logic [3:0] a, input logic [3:0] b, input int poke);
    logic [3:0] e1, e2, e3, e4, e5;
    e1 = 4'd0;
    e2 = a;
    e3 = 4'(a + a);
    e4 = 4'(a + a + b);
    e5 = 4'(a + a + b + 4'd1);
    @(negedge clk);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    @(negedge clk);                    // edge k has passed
    start = 1'b0;
    check("R6 done drops after start", {4'd0, done}, 5'd0);
    for (int s = 1; s <= 5; s++) begin
      @(negedge clk);
      case (s)
        1: check("R3 step clear", {1'b0, acc_d}, {1'b0, e1});
        2: check("R3 step add A", {1'b0, acc_d}, {1'b0, e2});
        3: check("R3 step add A again", {1'b0, acc_d}, {1'b0, e3});
        4: check("R3 step add B", {1'b0, acc_d}, {1'b0, e4});
        default: begin
          check("R2 final result", {1'b0, acc_d}, {1'b0, e5});
          check("R2 done raised", {4'd0, done}, 5'd1);
        end
      endcase
      if (s < 5) check("R9 done low while busy", {4'd0, done}, 5'd0);
      start = (s == poke && s < 5);
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    op_a  = 4'd9;
    op_b  = 4'd5;
    repeat (3) @(negedge clk);
    check("R1 acc in reset", {1'b0, acc_d}, 5'd0);
    check("R1 done in reset", {4'd0, done}, 5'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 acc idle after reset", {1'b0, acc_d}, 5'd0);
    check("R1 done idle after reset", {4'd0, done}, 5'd0);
  endtask

  task automatic t_basic();
    run_prog(4'd3, 4'd2, 0);           // 9
    run_prog(4'd0, 4'd0, 0);           // 1
  endtask

  task automatic t_wrap();
    run_prog(4'd15, 4'd15, 0);         // R7: 46 mod 16 = 14
    check("R7 wrap value", {1'b0, acc_d}, 5'd14);
    run_prog(4'd8, 4'd0, 0);           // R7: 17 mod 16 = 1
    check("R7 wrap 2A", {1'b0, acc_d}, 5'd1);
  endtask

  task automatic t_hold();
    logic [3:0] held;
    run_prog(4'd5, 4'd6, 0);
    held = acc_d;
    op_a = 4'd1;
    op_b = 4'd14;
    repeat (10) @(negedge clk);
    check("R4 result held", {1'b0, acc_d}, {1'b0, held});
    check("R4 done held", {4'd0, done}, 5'd1);
  endtask

  task automatic t_busy_start();
    for (int p = 1; p <= 4; p++) begin
      run_prog(4'(p + 6), 4'(p * 3), p);   // R5: extra start ignored
      repeat (2) @(negedge clk);
      check("R5 no relaunch after busy start", {4'd0, done}, 5'd1);
    end
  endtask

  task automatic t_restart();
    run_prog(4'd2, 4'd7, 0);           // 12
    run_prog(4'd11, 4'd4, 0);          // R6: restart from done, 27 mod 16 = 11
    check("R6 restart result", {1'b0, acc_d}, 5'd11);
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_prog(4'(a), 4'(b), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_hold();
    t_busy_start();
    t_restart();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule